// File: doc/BRIEF.md
# Mode Register Load Checker

This block watches the command bus of a double-data-rate SDRAM and catches every load-mode-register command. The two bank-select bits decide which register the command writes. Bank value 0 writes the base mode register, and bank value 1 writes the extended mode register. The block keeps a shadow copy of each register and decodes the fields that the rest of the controller or a monitor needs. From the base register it decodes burst length, burst ordering, read latency and the DLL-reset request. From the extended register it decodes DLL enable, drive strength and the QFC output enable.

The block also checks the rules that link commands together. It flags encodings that fall in reserved space. It flags a load issued while any bank is open or a burst is running. It also flags a DLL enable that is not followed, at the next base load, by a DLL reset request. Each kind of violation has its own sticky bit, which holds until it is cleared.

The block only observes the bus and never stalls it. The command strobe is a single-cycle qualifier with no ready and no back-pressure. A command on the bus is taken in the cycle its strobe is high, and every output it affects changes at that clock edge. Generating commands and timing the waits between them are left to other logic.

Top module: `mode_reg_load_checker`

## Requirements
- R1: A load with bank bits 00 writes the base shadow register. Address bits [2:0] give the burst length: 001 gives 2 beats, 010 gives 4 beats and 011 gives 8 beats. Any other code reads as 0 beats and sets `err_reserved`.
- R2: Base address bit 3 selects the burst ordering. A value of 1 gives interleaved order (`burst_interleave` = 1), and a value of 0 gives sequential order.
- R3: Base address bits [6:4] give the read latency in half cycles. Code 010 gives `cas_lat_x2` = 4, and code 110 gives 5. Any other code gives 0 and sets `err_reserved`.
- R4: Base address bits [12:7] give the operating mode. All zero means normal operation. Only bit 8 set means normal operation with DLL reset (`op_dll_reset` = 1). Any other value sets `err_reserved`.
- R5: A load with bank bits 01 writes the extended shadow register. Address bit 0 = 0 enables the DLL (`dll_enabled` = 1). Bit 1 = 1 selects reduced drive strength, and bit 2 = 1 enables QFC. Non-zero bits [12:3] set `err_reserved`. A load with bank bit 1 high sets `err_reserved` and writes neither register.
- R6: A load issued while any bit of `bank_open` is set, or while `burst_active` is high, sets `err_busy`. The load still updates its register.
- R7: An extended load that enables the DLL arms a pending-reset flag. The next base load clears the flag, and it sets `err_dll_seq` if that base load does not request a DLL reset. An extended load that disables the DLL clears the flag without an error.
- R8: While no load is issued, every decoded output keeps its value.
- R9: After reset both shadow registers are zero and all error bits are low. `mode_unset` stays high until the first base load.
- R10: Error bits are sticky. `err_clear` drops them at the next edge, but a violation in the same cycle as a clear still sets its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_lmr | input | 1 | Load-mode-register command strobe |
| cmd_ba | input | 2 | Bank-select bits of the command |
| cmd_addr | input | ADDR_W | Address bus carrying the register value |
| bank_open | input | NBANK | One bit per bank, high while that bank is open |
| burst_active | input | 1 | High while a data burst is in progress |
| err_clear | input | 1 | Clears the sticky error bits |
| burst_beats | output | 4 | Decoded burst length (2, 4, 8, or 0 if reserved) |
| burst_interleave | output | 1 | 1 for interleaved burst order |
| cas_lat_x2 | output | 3 | Read latency in half cycles (4, 5, or 0 if reserved) |
| op_dll_reset | output | 1 | Base register requests a DLL reset |
| mode_unset | output | 1 | No base load has happened since reset |
| dll_enabled | output | 1 | Extended register has the DLL enabled |
| drive_reduced | output | 1 | Reduced output drive selected |
| qfc_enabled | output | 1 | QFC output function enabled |
| err_reserved | output | 1 | Sticky: a reserved encoding or bank value was loaded |
| err_busy | output | 1 | Sticky: a load occurred with a bank open or a burst active |
| err_dll_seq | output | 1 | Sticky: a DLL enable was not followed by a DLL reset |

## Verification
Every legal burst-length code and every latency code is loaded, and so is a reserved code of each kind. This separates a correct field decode from one that mixes up neighbouring codes or lets reserved space through without an error. The operating-mode field is driven with all zeros, with bit 8 alone and with another bit, which tells the DLL-reset decode apart from the reserved-space check. The DLL sequence is run three ways: enable then reset, enable then no reset, and disable then no reset. This shows that the pending flag is armed and disarmed by the right commands. Loads issued with a bank open and with a burst active, clears with and without a coinciding violation, and idle stretches show that the busy check, the sticky behaviour and value retention work independently.

// File: rtl/mrl_pkg.sv
package mrl_pkg;
  localparam int MODE_BITS = 13;

  typedef struct packed {
    logic [3:0] beats;
    logic       ilv;
    logic [2:0] cas_x2;
    logic       dll_rst;
    logic       rsv;
  } base_fields_t;

  typedef struct packed {
    logic dll_on;
    logic drv_red;
    logic qfc;
    logic rsv;
  } ext_fields_t;
endpackage

// File: rtl/mrl_base_decode.sv
module mrl_base_decode
  import mrl_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] word,
  output base_fields_t      fields
);
  logic bl_bad, cas_bad, op_bad;
  logic [5:0] op;

  always_comb begin
    op = word[12:7];
    fields = '0;
    bl_bad = 1'b0;
    cas_bad = 1'b0;
    case (word[2:0])
      3'b001: fields.beats = 4'd2;
      3'b010: fields.beats = 4'd4;
      3'b011: fields.beats = 4'd8;
      default: bl_bad = 1'b1;
    endcase
    fields.ilv = word[3];
    case (word[6:4])
      3'b010: fields.cas_x2 = 3'd4;
      3'b110: fields.cas_x2 = 3'd5;
      default: cas_bad = 1'b1;
    endcase
    fields.dll_rst = (op == 6'b000010);
    op_bad = (op != 6'b000000) && !fields.dll_rst;
    fields.rsv = bl_bad | cas_bad | op_bad;
  end
endmodule

// File: rtl/mrl_ext_decode.sv
module mrl_ext_decode
  import mrl_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] word,
  output ext_fields_t       fields
);
  always_comb begin
    fields.dll_on  = ~word[0];
    fields.drv_red = word[1];
    fields.qfc     = word[2];
    fields.rsv     = |word[ADDR_W-1:3];
  end
endmodule

// File: rtl/mrl_rules.sv
module mrl_rules
  import mrl_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_base,
  input  logic             wr_ext,
  input  logic             wr_bad_bank,
  input  base_fields_t     in_base,
  input  ext_fields_t      in_ext,
  input  logic [NBANK-1:0] bank_open,
  input  logic             burst_active,
  input  logic             err_clear,
  output logic             err_reserved,
  output logic             err_busy,
  output logic             err_dll_seq
);
  logic any_load, v_rsv, v_busy, v_dll, dll_pending;

  always_comb begin
    any_load = wr_base | wr_ext | wr_bad_bank;
    v_rsv  = wr_bad_bank | (wr_base & in_base.rsv) | (wr_ext & in_ext.rsv);
    v_busy = any_load & ((|bank_open) | burst_active);
    v_dll  = wr_base & dll_pending & ~in_base.dll_rst;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dll_pending  <= 1'b0;
      err_reserved <= 1'b0;
      err_busy     <= 1'b0;
      err_dll_seq  <= 1'b0;
    end else begin
      if (wr_ext)       dll_pending <= in_ext.dll_on;
      else if (wr_base) dll_pending <= 1'b0;
      err_reserved <= v_rsv  | (err_reserved & ~err_clear);
      err_busy     <= v_busy | (err_busy     & ~err_clear);
      err_dll_seq  <= v_dll  | (err_dll_seq  & ~err_clear);
    end
  end
endmodule

// File: rtl/mode_reg_load_checker.sv
module mode_reg_load_checker
  import mrl_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int NBANK  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_lmr,
  input  logic [1:0]        cmd_ba,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [NBANK-1:0]  bank_open,
  input  logic              burst_active,
  input  logic              err_clear,
  output logic [3:0]        burst_beats,
  output logic              burst_interleave,
  output logic [2:0]        cas_lat_x2,
  output logic              op_dll_reset,
  output logic              mode_unset,
  output logic              dll_enabled,
  output logic              drive_reduced,
  output logic              qfc_enabled,
  output logic              err_reserved,
  output logic              err_busy,
  output logic              err_dll_seq
);
  logic [ADDR_W-1:0] base_q, ext_q;
  logic wr_base, wr_ext, wr_bad;
  base_fields_t in_base, sh_base;
  ext_fields_t  in_ext, sh_ext;

  assign wr_base = cmd_lmr && (cmd_ba == 2'b00);
  assign wr_ext  = cmd_lmr && (cmd_ba == 2'b01);
  assign wr_bad  = cmd_lmr && cmd_ba[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      ext_q      <= '0;
      mode_unset <= 1'b1;
    end else begin
      if (wr_base) begin
        base_q     <= cmd_addr;
        mode_unset <= 1'b0;
      end
      if (wr_ext) ext_q <= cmd_addr;
    end
  end

  mrl_base_decode #(.ADDR_W(ADDR_W)) u_in_base (.word(cmd_addr), .fields(in_base));
  mrl_ext_decode  #(.ADDR_W(ADDR_W)) u_in_ext  (.word(cmd_addr), .fields(in_ext));
  mrl_base_decode #(.ADDR_W(ADDR_W)) u_sh_base (.word(base_q),   .fields(sh_base));
  mrl_ext_decode  #(.ADDR_W(ADDR_W)) u_sh_ext  (.word(ext_q),    .fields(sh_ext));

  mrl_rules #(.NBANK(NBANK)) u_rules (
    .clk(clk), .rst_n(rst_n),
    .wr_base(wr_base), .wr_ext(wr_ext), .wr_bad_bank(wr_bad),
    .in_base(in_base), .in_ext(in_ext),
    .bank_open(bank_open), .burst_active(burst_active),
    .err_clear(err_clear),
    .err_reserved(err_reserved), .err_busy(err_busy), .err_dll_seq(err_dll_seq)
  );

  assign burst_beats      = sh_base.beats;
  assign burst_interleave = sh_base.ilv;
  assign cas_lat_x2       = sh_base.cas_x2;
  assign op_dll_reset     = sh_base.dll_rst;
  assign dll_enabled      = sh_ext.dll_on;
  assign drive_reduced    = sh_ext.drv_red;
  assign qfc_enabled      = sh_ext.qfc;
endmodule

// File: rtl/mrl_checker.sv
module mrl_checker #(
  parameter int ADDR_W = 13,
  parameter int NBANK  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_lmr,
  input logic [1:0]        cmd_ba,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [NBANK-1:0]  bank_open,
  input logic              burst_active,
  input logic              err_clear,
  input logic [3:0]        burst_beats,
  input logic [2:0]        cas_lat_x2,
  input logic              mode_unset,
  input logic              dll_enabled,
  input logic              err_reserved,
  input logic              err_busy,
  input logic              err_dll_seq
);
  assert_busy_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lmr && ((|bank_open) || burst_active) |=> err_busy);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_lmr |=> $stable(burst_beats) && $stable(cas_lat_x2) && $stable(dll_enabled));

  assert_unset_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lmr && cmd_ba == 2'b00 |=> !mode_unset);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_reserved || err_busy || err_dll_seq) && !err_clear |=>
      $countones({err_reserved, err_busy, err_dll_seq}) >= 1);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear && !cmd_lmr |=> !err_reserved && !err_busy && !err_dll_seq);

  assert_bad_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lmr && cmd_ba[1] |=> err_reserved && $stable(burst_beats) && $stable(dll_enabled));
endmodule

bind mode_reg_load_checker mrl_checker #(.ADDR_W(ADDR_W), .NBANK(NBANK)) u_mrl_checker (
  .clk(clk), .rst_n(rst_n), .cmd_lmr(cmd_lmr), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
  .bank_open(bank_open), .burst_active(burst_active), .err_clear(err_clear),
  .burst_beats(burst_beats), .cas_lat_x2(cas_lat_x2), .mode_unset(mode_unset),
  .dll_enabled(dll_enabled), .err_reserved(err_reserved), .err_busy(err_busy),
  .err_dll_seq(err_dll_seq)
);

// File: tb/tb_mode_reg_load_checker.sv
module tb_mode_reg_load_checker;
  localparam int ADDR_W = 13;
  localparam int NBANK  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_lmr = 1'b0;
  logic [1:0] cmd_ba = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [NBANK-1:0] bank_open = '0;
  logic burst_active = 1'b0;
  logic err_clear = 1'b0;
  logic [3:0] burst_beats;
  logic burst_interleave;
  logic [2:0] cas_lat_x2;
  logic op_dll_reset, mode_unset, dll_enabled, drive_reduced, qfc_enabled;
  logic err_reserved, err_busy, err_dll_seq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mode_reg_load_checker #(.ADDR_W(ADDR_W), .NBANK(NBANK)) dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic lmr(input logic [1:0] ba, input logic [12:0] a);
    @(negedge clk);
    cmd_lmr = 1'b1; cmd_ba = ba; cmd_addr = a;
    @(negedge clk);
    cmd_lmr = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); err_clear = 1'b1;
    @(negedge clk); err_clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 unset", mode_unset, 1);
    check("R9 beats", burst_beats, 0);
    check("R9 errs", {err_reserved, err_busy, err_dll_seq}, 0);
  endtask

  task automatic t_burst_len();
    int exp_b[8] = '{0, 2, 4, 8, 0, 0, 0, 0};
    for (int c = 0; c < 8; c++) begin
      clr();
      lmr(2'b00, 13'h020 | 13'(c));
      check("R1 beats", burst_beats, exp_b[c]);
      check("R1 rsv", err_reserved, exp_b[c] == 0);
    end
    check("R9 unset after base", mode_unset, 0);
  endtask

  task automatic t_order();
    lmr(2'b00, 13'h02A);
    check("R2 interleave", burst_interleave, 1);
    lmr(2'b00, 13'h022);
    check("R2 sequential", burst_interleave, 0);
  endtask

  task automatic t_cas();
    for (int c = 0; c < 8; c++) begin
      clr();
      lmr(2'b00, 13'(c << 4) | 13'h002);
      check("R3 cas", cas_lat_x2, c == 2 ? 4 : (c == 6 ? 5 : 0));
      check("R3 rsv", err_reserved, (c != 2 && c != 6));
    end
  endtask

  task automatic t_opmode();
    clr(); lmr(2'b00, 13'h122);
    check("R4 dll reset", op_dll_reset, 1);
    check("R4 legal", err_reserved, 0);
    lmr(2'b00, 13'h022);
    check("R4 normal", op_dll_reset, 0);
    check("R4 normal legal", err_reserved, 0);
    lmr(2'b00, 13'h0A2);
    check("R4 reserved", err_reserved, 1);
    clr(); lmr(2'b00, 13'h322);
    check("R4 two bits", err_reserved, 1);
  endtask

  task automatic t_ext();
    clr(); lmr(2'b01, 13'h006);
    check("R5 dll on", dll_enabled, 1);
    check("R5 drive", drive_reduced, 1);
    check("R5 qfc", qfc_enabled, 1);
    check("R5 legal", err_reserved, 0);
    lmr(2'b01, 13'h001);
    check("R5 dll off", dll_enabled, 0);
    check("R5 drive off", drive_reduced, 0);
    lmr(2'b01, 13'h008);
    check("R5 ext rsv", err_reserved, 1);
    clr(); lmr(2'b00, 13'h062);
    lmr(2'b10, 13'h001);
    check("R5 bad bank", err_reserved, 1);
    check("R5 base kept", cas_lat_x2, 5);
  endtask

  task automatic t_busy();
    clr();
    bank_open = 4'b0100; lmr(2'b00, 13'h032);
    bank_open = '0;
    check("R6 bank open", err_busy, 1);
    check("R6 still written", cas_lat_x2, 0);
    clr();
    burst_active = 1'b1; lmr(2'b00, 13'h022);
    burst_active = 1'b0;
    check("R6 burst", err_busy, 1);
    clr(); lmr(2'b00, 13'h022);
    check("R6 idle", err_busy, 0);
  endtask

  task automatic t_dll_seq();
    clr(); lmr(2'b01, 13'h000); lmr(2'b00, 13'h122);
    check("R7 enable then reset", err_dll_seq, 0);
    lmr(2'b01, 13'h000); lmr(2'b00, 13'h022);
    check("R7 missing reset", err_dll_seq, 1);
    clr(); lmr(2'b00, 13'h022);
    check("R7 disarmed", err_dll_seq, 0);
    lmr(2'b01, 13'h000); lmr(2'b01, 13'h001); lmr(2'b00, 13'h022);
    check("R7 disable disarms", err_dll_seq, 0);
  endtask

  task automatic t_hold();
    lmr(2'b00, 13'h06B);
    repeat (5) @(negedge clk);
    check("R8 beats", burst_beats, 8);
    check("R8 ilv", burst_interleave, 1);
    check("R8 cas", cas_lat_x2, 5);
  endtask

  task automatic t_sticky();
    clr(); lmr(2'b00, 13'h000);
    repeat (3) @(negedge clk);
    check("R10 sticky", err_reserved, 1);
    @(negedge clk); err_clear = 1'b1; cmd_lmr = 1'b1; cmd_ba = 2'b11;
    @(negedge clk); err_clear = 1'b0; cmd_lmr = 1'b0;
    check("R10 set wins", err_reserved, 1);
    clr();
    check("R10 cleared", err_reserved, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_burst_len();
    t_order();
    t_cas();
    t_opmode();
    t_ext();
    t_busy();
    t_dll_seq();
    t_hold();
    t_sticky();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule